// File: doc/BRIEF.md
# Row-Tag Discriminator Allocator

This block sits at the entry of a streaming accumulation datapath. Values arrive one per cycle, each carrying a wide row index. Inside the datapath, rows in flight are identified by a short tag rather than by the full index. The allocator gives that tag to each arriving value. When the row index differs from the index of the last accepted value, the block takes a free tag, marks the value as the first of a new row, and keeps that tag for the values of the same row that follow.

Downstream logic hands a tag back through the release port once its row has been fully reduced and has left the datapath. The tag then returns to the free pool. The pool is a bitmask. A release that arrives in the same cycle as an allocation is visible to that allocation, so a full pool can recover without losing a cycle. The tag width is set by the bound on rows in flight, not by the width of the row index.

Top module: `row_tag_alloc`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid`, `out_new_row` and `tags_exhausted` are 0. The first valid value after reset always begins a new row.
- R2: A valid value whose row index equals the index of the last accepted value produces `out_valid`=1 and `out_new_row`=0. Its `out_tag` is the tag that was given to that row.
- R3: A new row receives the lowest-numbered free tag. Tag k corresponds to bit k of the free mask.
- R4: The outputs for a value appear exactly one clock cycle after `in_valid` is sampled high. A cycle with `in_valid` low gives `out_valid`=0 in the next cycle.
- R5: A release with `rel_valid`=1 returns tag `rel_tag` to the free pool, so a later new row can receive it. Releasing a tag that is already free changes nothing, and a `rel_tag` value at or above the tag count is ignored.
- R6: A tag released in a given cycle can be allocated to a new row in that same cycle, including when no other tag is free.
- R7: `tags_exhausted` is 1 exactly when no tag is free in the registered pool. It rises in the cycle after the allocation that takes the last free tag.
- R8: A new row that finds no free tag, with no release in the same cycle, is dropped: `out_valid` stays 0 and the remembered row index does not change. The next value with that index is therefore treated as a new row again.
- R9: Idle cycles do not end a row. The comparison is always made against the last accepted index, however many cycles with `in_valid` low have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An incoming value is present this cycle |
| in_row | input | ROW_W | Row index of the incoming value |
| rel_valid | input | 1 | A tag is being returned this cycle |
| rel_tag | input | TAG_W | Tag being returned |
| out_valid | output | 1 | Tagged value is valid (one cycle after input) |
| out_tag | output | TAG_W | Tag attached to the value |
| out_new_row | output | 1 | The value is the first of a new row |
| tags_exhausted | output | 1 | No tag is free in the pool |

## Verification
The bench builds the block with four tags and an 8-bit row index. With only four tags, a few new rows are enough to fill the pool, so the full, drop and same-cycle-recovery paths are all easy to reach. It sweeps all sixteen subsets of released tags from a full pool and checks that the next row receives the lowest freed tag. Directed sequences cover continuation across idle gaps, redundant releases, out-of-range release values and a release arriving together with an allocation.

// File: rtl/rta_pkg.sv
// Package: shared types for the row-tag allocator.
// Assumes: nothing beyond IEEE 1800-2017.
package rta_pkg;

    // Outcome of the current input cycle as seen by the row tracker.
    typedef enum logic [1:0] {
        EV_IDLE = 2'd0,   // no valid input
        EV_CONT = 2'd1,   // value continues the current row
        EV_NEW  = 2'd2,   // value opens a row and a tag was granted
        EV_DROP = 2'd3    // value opens a row but no tag was free
    } rta_event_e;

endpackage

// File: rtl/rta_low_pick.sv
// Module: lowest-set-bit picker.
// Finds the lowest set bit of a mask and returns its index.
// Assumes: W is wide enough to encode N-1.
module rta_low_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] mask,
    output logic         any,
    output logic [W-1:0] idx
);

    logic [N:0]   seen;
    logic [N-1:0] first;

    assign seen[0] = 1'b0;

    // One stage per bit: a bit is first if no lower bit was set.
    generate
        for (genvar g = 0; g < N; g++) begin : g_chain
            assign seen[g+1] = seen[g] | mask[g];
            assign first[g]  = mask[g] & ~seen[g];
        end
    endgenerate

    assign any = seen[N];

    // Encode the one-hot first vector into an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx = idx | W'(i);
        end
    end

endmodule

// File: rtl/rta_free_pool.sv
// Module: free-tag pool.
// Keeps a bitmask of free tags (bit k set = tag k free). A release
// in the current cycle is merged in before the pick, so a freshly
// returned tag can be granted in the same cycle.
// Assumes: alloc_req is only raised for a value that needs a tag.
module rta_free_pool #(
    parameter int TAG_COUNT = 4,
    parameter int TAG_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             rel_valid,
    input  logic [TAG_W-1:0] rel_tag,
    output logic             grant,
    output logic [TAG_W-1:0] grant_tag,
    output logic [TAG_COUNT-1:0] avail,
    output logic             exhausted
);

    localparam logic [TAG_W:0] CNT_V = TAG_COUNT[TAG_W:0];

    logic [TAG_COUNT-1:0] free_q;
    logic [TAG_COUNT-1:0] rel_hot;
    logic [TAG_COUNT-1:0] take_hot;
    logic                 any_free;

    // Decode the release into a one-hot mask, ignoring out-of-range tags.
    always_comb begin
        rel_hot = '0;
        if (rel_valid && ({1'b0, rel_tag} < CNT_V)) rel_hot[rel_tag] = 1'b1;
    end

    assign avail = free_q | rel_hot;

    rta_low_pick #(.N(TAG_COUNT), .W(TAG_W)) u_pick (
        .mask (avail),
        .any  (any_free),
        .idx  (grant_tag)
    );

    assign grant = alloc_req & any_free;

    // Mask of the tag leaving the pool this cycle.
    always_comb begin
        take_hot = '0;
        if (grant) take_hot[grant_tag] = 1'b1;
    end

    // Update the free mask: add releases, remove the granted tag.
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= avail & ~take_hot;
    end

    assign exhausted = ~|free_q;

endmodule

// File: rtl/rta_row_track.sv
// Module: row tracker.
// Remembers the last accepted row index and its tag, decides whether
// the current value opens a new row, and classifies the cycle.
// Assumes: grant/grant_tag come from the pool for this cycle's request.
module rta_row_track
    import rta_pkg::*;
#(
    parameter int ROW_W = 16,
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ROW_W-1:0] in_row,
    input  logic             grant,
    input  logic [TAG_W-1:0] grant_tag,
    output logic             alloc_req,
    output rta_event_e       ev,
    output logic [TAG_W-1:0] held_tag
);

    logic             have_q;
    logic [ROW_W-1:0] prev_q;
    logic [TAG_W-1:0] tag_q;

    // Detect a row change against the last accepted index.
    always_comb begin
        alloc_req = in_valid && (!have_q || (in_row != prev_q));
    end

    // Classify the cycle for the output stage.
    always_comb begin
        if (!in_valid)       ev = EV_IDLE;
        else if (!alloc_req) ev = EV_CONT;
        else if (grant)      ev = EV_NEW;
        else                 ev = EV_DROP;
    end

    // Remember the row and its tag only when a new row is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            prev_q <= '0;
            tag_q  <= '0;
        end else if (ev == EV_NEW) begin
            have_q <= 1'b1;
            prev_q <= in_row;
            tag_q  <= grant_tag;
        end
    end

    assign held_tag = tag_q;

endmodule

// File: rtl/row_tag_alloc.sv
// Module: row-tag allocator (top).
// Gives each incoming value a short tag naming its row, with a
// registered output one cycle after the input. Tags come from a
// bitmask pool and return to it through the release port.
// Assumes: a row is not released while its values are still arriving.
module row_tag_alloc
    import rta_pkg::*;
#(
    parameter int ROW_W     = 16,
    parameter int TAG_COUNT = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [ROW_W-1:0]               in_row,
    input  logic                           rel_valid,
    input  logic [$clog2(TAG_COUNT)-1:0]   rel_tag,
    output logic                           out_valid,
    output logic [$clog2(TAG_COUNT)-1:0]   out_tag,
    output logic                           out_new_row,
    output logic                           tags_exhausted
);

    localparam int TAG_W = $clog2(TAG_COUNT);

    logic                 alloc_req;
    logic                 grant;
    logic [TAG_W-1:0]     grant_tag;
    logic [TAG_COUNT-1:0] pool_avail;
    logic [TAG_W-1:0]     held_tag;
    rta_event_e           ev;

    rta_free_pool #(.TAG_COUNT(TAG_COUNT), .TAG_W(TAG_W)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_req (alloc_req),
        .rel_valid (rel_valid),
        .rel_tag   (rel_tag),
        .grant     (grant),
        .grant_tag (grant_tag),
        .avail     (pool_avail),
        .exhausted (tags_exhausted)
    );

    rta_row_track #(.ROW_W(ROW_W), .TAG_W(TAG_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_row    (in_row),
        .grant     (grant),
        .grant_tag (grant_tag),
        .alloc_req (alloc_req),
        .ev        (ev),
        .held_tag  (held_tag)
    );

    // Register the tagged result one cycle after the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_new_row <= 1'b0;
            out_tag     <= '0;
        end else begin
            out_valid   <= (ev == EV_CONT) || (ev == EV_NEW);
            out_new_row <= (ev == EV_NEW);
            out_tag     <= (ev == EV_NEW) ? grant_tag : held_tag;
        end
    end

endmodule

// File: rtl/rta_checker.sv
// Module: property checker for row_tag_alloc, attached by bind.
// Assumes: it sees the top's ports plus the pool request/grant nets.
module rta_checker #(
    parameter int TAG_COUNT = 4,
    parameter int TAG_W     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 rel_valid,
    input logic [TAG_W-1:0]     rel_tag,
    input logic                 out_valid,
    input logic [TAG_W-1:0]     out_tag,
    input logic                 out_new_row,
    input logic                 tags_exhausted,
    input logic                 alloc_req,
    input logic                 grant,
    input logic [TAG_W-1:0]     grant_tag,
    input logic [TAG_COUNT-1:0] pool_avail
);

    logic [TAG_COUNT-1:0] below_mask;

    // Bits strictly below the granted tag.
    always_comb begin
        below_mask = (TAG_COUNT'(1) << grant_tag) - TAG_COUNT'(1);
    end

    // R4: an idle input cycle yields no output.
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: a value on the current row comes out as a continuation.
    a_r2_cont_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !alloc_req) |=> (out_valid && !out_new_row));

    // R3: the granted tag is free and nothing lower is free.
    a_r3_lowest_pick: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (pool_avail[grant_tag] && ((pool_avail & below_mask) == '0)));

    // R8: a new row with no free tag and no release is dropped.
    a_r8_drop_when_exhausted: assert property (@(posedge clk) disable iff (!rst_n)
        (tags_exhausted && !rel_valid && alloc_req) |=> !out_valid);

    // R7: the pool only becomes exhausted through an allocation.
    a_r7_exhaust_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tags_exhausted) |-> $past(grant));

    // R1: the new-row flag never appears without a valid output.
    a_r1_new_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_new_row |-> out_valid);

    // R6: with an empty pool, a same-cycle release is handed straight out.
    a_r6_release_reused: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && tags_exhausted && alloc_req && ({1'b0, rel_tag} < (TAG_W+1)'(TAG_COUNT)))
        |=> (out_valid && out_new_row && (out_tag == $past(rel_tag))));

endmodule

bind row_tag_alloc rta_checker #(.TAG_COUNT(TAG_COUNT), .TAG_W(TAG_W)) u_rta_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .rel_valid      (rel_valid),
    .rel_tag        (rel_tag),
    .out_valid      (out_valid),
    .out_tag        (out_tag),
    .out_new_row    (out_new_row),
    .tags_exhausted (tags_exhausted),
    .alloc_req      (alloc_req),
    .grant          (grant),
    .grant_tag      (grant_tag),
    .pool_avail     (pool_avail)
);

// File: tb/tb_row_tag_alloc.sv
// Bench: four tags, 8-bit rows, model-predicted outputs per step.
module tb_row_tag_alloc;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W      = 8;
    localparam int TAG_COUNT  = 4;
    localparam int TAG_W      = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [ROW_W-1:0] in_row = '0;
    logic             rel_valid = 1'b0;
    logic [TAG_W-1:0] rel_tag = '0;
    logic             out_valid;
    logic [TAG_W-1:0] out_tag;
    logic             out_new_row;
    logic             tags_exhausted;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Bench model state.
    logic [TAG_COUNT-1:0] m_free = '1;
    bit                   m_have = 1'b0;
    logic [ROW_W-1:0]     m_prev = '0;
    int                   m_tag  = 0;
    int                   row_ctr = 16;

    row_tag_alloc #(.ROW_W(ROW_W), .TAG_COUNT(TAG_COUNT)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_row         (in_row),
        .rel_valid      (rel_valid),
        .rel_tag        (rel_tag),
        .out_valid      (out_valid),
        .out_tag        (out_tag),
        .out_new_row    (out_new_row),
        .tags_exhausted (tags_exhausted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, predict, check at the next falling edge.
    task automatic step(input bit v, input int row, input bit rv, input int rt, input string req);
        logic [TAG_COUNT-1:0] avail;
        bit isnew;
        bit ev_v;
        bit ev_n;
        int ev_t;
        int pick;
        in_valid  = v;
        in_row    = ROW_W'(row);
        rel_valid = rv;
        rel_tag   = TAG_W'(rt);
        avail = m_free;
        if (rv && rt < TAG_COUNT) avail[rt] = 1'b1;
        isnew = v && (!m_have || (ROW_W'(row) != m_prev));
        ev_v = 1'b0; ev_n = 1'b0; ev_t = m_tag;
        if (v && !isnew) begin
            ev_v = 1'b1;
        end else if (isnew && avail != '0) begin
            pick = 0;
            for (int k = TAG_COUNT - 1; k >= 0; k--) if (avail[k]) pick = k;
            avail[pick] = 1'b0;
            ev_v = 1'b1; ev_n = 1'b1; ev_t = pick;
            m_prev = ROW_W'(row); m_have = 1'b1; m_tag = pick;
        end
        m_free = avail;
        @(negedge clk);
        check(req, "out_valid", int'(out_valid), int'(ev_v));
        check(req, "out_new_row", int'(out_new_row), int'(ev_n));
        if (ev_v) check(req, "out_tag", int'(out_tag), ev_t);
        check("R7", "tags_exhausted", int'(tags_exhausted), int'(m_free == '0));
    endtask

    task automatic fresh_row(output int r);
        row_ctr++;
        r = row_ctr;
    endtask

    initial begin
        int r;
        int r0;
        // Reset state (R1).
        repeat (2) @(negedge clk);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "exhausted in reset", int'(tags_exhausted), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "out_new_row after reset", int'(out_new_row), 0);

        // Idle cycles (R4).
        step(0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, "R4");

        // First value, index 0, still opens a row (R1), then continuation (R2).
        step(1, 0, 0, 0, "R1");
        step(1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R2");
        // Idle gap does not end the row (R9).
        step(0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, "R9");

        // Fill the pool (R3, R7).
        step(1, 5, 0, 0, "R3");
        step(1, 6, 0, 0, "R3");
        step(1, 6, 0, 0, "R2");
        step(1, 7, 0, 0, "R3");
        step(0, 0, 0, 0, "R7");

        // Drop while exhausted (R8), then same-cycle release recovers (R6).
        step(1, 9, 0, 0, "R8");
        step(1, 9, 0, 0, "R8");
        step(1, 9, 1, 2, "R6");
        step(1, 9, 0, 0, "R2");

        // Release and redundant release (R5).
        step(0, 0, 1, 1, "R5");
        step(0, 0, 1, 1, "R5");
        step(1, 11, 0, 0, "R5");
        step(1, 12, 0, 0, "R8");

        // Sweep all release subsets from a full pool (R3, R5).
        for (int s = 0; s < 16; s++) begin
            for (int t = 0; t < TAG_COUNT; t++) step(0, 0, 1, t, "R5");
            for (int t = 0; t < TAG_COUNT; t++) begin
                fresh_row(r);
                step(1, r, 0, 0, "R3");
            end
            for (int t = 0; t < TAG_COUNT; t++) if (s[t]) step(0, 0, 1, t, "R5");
            fresh_row(r0);
            step(1, r0, 0, 0, "R3");
            step(1, r0, 0, 0, "R2");
        end

        // Same-cycle release and allocation with other tags free (R6).
        for (int t = 0; t < TAG_COUNT; t++) step(0, 0, 1, t, "R5");
        for (int t = 0; t < TAG_COUNT - 1; t++) begin
            fresh_row(r);
            step(1, r, 0, 0, "R3");
        end
        fresh_row(r);
        step(1, r, 1, 1, "R6");
        step(0, 0, 0, 0, "R4");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule